// File: doc/BRIEF.md
# Linked-Descriptor Stream DMA Walker

The walker follows a chain of data descriptors held in a word-addressed descriptor memory. It moves the bytes of each descriptor's buffer, one byte per beat, out of a separate buffer memory onto a valid/ready byte stream. Each descriptor is four 32-bit words at consecutive word addresses. Word 0 is the next-descriptor word address. Word 1 is the buffer start byte address. Word 2 holds the flags. Word 3 is the byte address just past the buffer. The buffer length is therefore the end address minus the start address.

Software controls the channel with level inputs for enable and stop, a one-cycle continue pulse and a one-cycle interrupt acknowledge pulse. When the chain reaches a descriptor marked as the last one, the channel parks in an end state. A continue pulse in that state fetches the same descriptor again. If software has meanwhile cleared its last marker and pointed its next word at new descriptors, the walk carries on from there without resending the old buffer.

Top module: `dlist_stream_walker`

## Requirements
- R1: A descriptor at word address P is fetched by reading words P, P+1, P+2 and P+3 in that order on the descriptor read port (one-cycle read latency). Word 0 is next, word 1 is start, word 2 is flags and word 3 is end.
- R2: In the flags word, only bit 0 (last), bit 3 (packet end) and bit 4 (interrupt request) act. Bit 5, bit 11, bits 31:16 and the other bits have no effect on the stream.
- R3: The bytes at addresses start up to end-1 leave in ascending order, one per accepted beat. The byte at address A is bits 8*A[1:0]+7 down to 8*A[1:0] of buffer word A>>2.
- R4: A descriptor whose start equals its end produces no beat, and the next descriptor is fetched.
- R5: `st_eop` is high on the final beat of a buffer whose flags bit 3 is set, and low on every other beat.
- R6: While `st_valid` is high and `st_ready` is low, the beat holds unchanged. No beat is dropped or repeated under backpressure.
- R7: After a descriptor without the last bit, the channel fetches the descriptor at its next word. After one with the last bit, `at_end` goes high and no further descriptor read happens.
- R8: A `cmd_cont` pulse while `at_end` is high re-reads the same four descriptor words. If bit 0 is still set, the channel returns to the end state. Otherwise it follows the freshly read next word without resending that buffer.
- R9: `irq` is set when a descriptor with flags bit 4 completes, including a zero-length one. It stays set until an `irq_ack` pulse, and a reload never sets it.
- R10: While `ctl_stop` is high, neither memory read port issues a read. A beat already presented stays presented. Dropping `ctl_stop` resumes with no byte lost.
- R11: With `ctl_en` low the channel returns to idle by the next cycle, with no stream beat and no reads. Raising `ctl_en` from idle starts a fetch at `first_desc_ptr`.
- R12: A `cmd_cont` pulse outside the end state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_en | input | 1 | Channel enable level |
| ctl_stop | input | 1 | Pause level |
| cmd_cont | input | 1 | Continue-data pulse |
| irq_ack | input | 1 | Write-one-to-clear pulse for `irq` |
| first_desc_ptr | input | 32 | Word address of the first descriptor |
| desc_rd_en | output | 1 | Descriptor memory read strobe |
| desc_rd_addr | output | DESC_AW | Descriptor memory word address |
| desc_rd_data | input | 32 | Descriptor word, one cycle after the strobe |
| buf_rd_en | output | 1 | Buffer memory read strobe |
| buf_rd_addr | output | BUF_AW | Buffer memory word address |
| buf_rd_data | input | 32 | Buffer word, one cycle after the strobe |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | 8 | Stream byte |
| st_eop | output | 1 | End of packet on this beat |
| irq | output | 1 | Sticky interrupt flag |
| at_end | output | 1 | Channel parked at end of list |

## Verification
The hardest situation to reach is a reload whose outcome depends on software editing memory while the channel is parked. The first part of it is a continue that finds the last bit still set and must only re-read four words. The second part is a continue after the last descriptor has been unlinked and pointed onward, where the old buffer must not reappear. The stimulus reaches this by leaving a three-descriptor chain parked, pulsing continue once on the unchanged memory, then rewriting the parked descriptor's next and flags words and pulsing continue again. The read-address log and the byte scoreboard are both compared afterwards. A pause is also held in the middle of a buffer while a stray continue arrives, to show that no read issues and nothing is lost or redone.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [15:0] meta;
    logic        in_eop;
    logic        wait_req;
    logic        irq_req;
    logic        out_eop;
    logic        last;
  } dflags_t;

  function automatic dflags_t decode_flags(input logic [WORD_W-1:0] w);
    dflags_t f;
    f.meta     = w[31:16];
    f.in_eop   = w[11];
    f.wait_req = w[5];
    f.irq_req  = w[4];
    f.out_eop  = w[3];
    f.last     = w[0];
    return f;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] lane);
    return w[int'(lane)*BYTE_W +: BYTE_W];
  endfunction

  function automatic logic is_final_byte(input logic [WORD_W-1:0] cur,
                                         input logic [WORD_W-1:0] stop_at);
    return (cur + 32'd1) == stop_at;
  endfunction
endpackage

// File: rtl/dlw_desc_seq.sv
module dlw_desc_seq
  import dlw_pkg::*;
#(
  parameter int DAW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pause,
  input  logic              cont,
  input  logic              irq_ack,
  input  logic [WORD_W-1:0] first_ptr,
  output logic              rd_en,
  output logic [DAW-1:0]    rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              mv_start,
  output logic [WORD_W-1:0] mv_src,
  output logic [WORD_W-1:0] mv_lim,
  output logic              mv_eop,
  input  logic              mv_done,
  output logic              in_xfer,
  output logic              evt_desc_done,
  output logic              irq,
  output logic              at_end
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_GO, S_XFER, S_FIN, S_END} dst_t;

  dst_t              state;
  logic [1:0]        idx;
  logic [DAW-1:0]    base;
  logic              reload;
  logic [WORD_W-1:0] w_next, w_start, w_flags, w_end;
  logic              irq_q;
  dflags_t           fl;

  assign fl = decode_flags(w_flags);

  logic unused_desc_bits;
  assign unused_desc_bits = ^{fl.meta, fl.in_eop, fl.wait_req, w_flags[2:1],
                              w_flags[10:6], w_flags[15:12], w_next[WORD_W-1:DAW],
                              first_ptr[WORD_W-1:DAW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      base    <= '0;
      reload  <= 1'b0;
      w_next  <= '0;
      w_start <= '0;
      w_flags <= '0;
      w_end   <= '0;
    end else if (!en) begin
      state  <= S_IDLE;
      idx    <= '0;
      reload <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          base   <= first_ptr[DAW-1:0];
          idx    <= '0;
          reload <= 1'b0;
          state  <= S_RD;
        end
        S_RD: if (!pause) state <= S_CAP;
        S_CAP: begin
          case (idx)
            2'd0:    w_next  <= rd_data;
            2'd1:    w_start <= rd_data;
            2'd2:    w_flags <= rd_data;
            default: w_end   <= rd_data;
          endcase
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            if (reload) begin
              reload <= 1'b0;
              if (fl.last) state <= S_END;
              else begin
                base  <= w_next[DAW-1:0];
                state <= S_RD;
              end
            end else begin
              state <= S_GO;
            end
          end else begin
            state <= S_RD;
          end
        end
        S_GO:   state <= S_XFER;
        S_XFER: if (mv_done) state <= S_FIN;
        S_FIN: begin
          if (fl.last) state <= S_END;
          else begin
            base  <= w_next[DAW-1:0];
            state <= S_RD;
          end
        end
        S_END: begin
          if (cont) begin
            reload <= 1'b1;
            idx    <= '0;
            state  <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign evt_desc_done = en && (state == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n)                           irq_q <= 1'b0;
    else if (evt_desc_done && fl.irq_req) irq_q <= 1'b1;
    else if (irq_ack)                     irq_q <= 1'b0;
  end

  assign rd_en    = en && (state == S_RD) && !pause;
  assign rd_addr  = base + DAW'(idx);
  assign mv_start = en && (state == S_GO);
  assign mv_src   = w_start;
  assign mv_lim   = w_end;
  assign mv_eop   = fl.out_eop;
  assign in_xfer  = (state == S_XFER);
  assign irq      = irq_q;
  assign at_end   = (state == S_END);

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_ack |=> irq_q);

  a_r7_no_fetch_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |-> !rd_en);

  a_r12_cont_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n || !en)
    cont && (state == S_XFER) && !mv_done |=> in_xfer);
endmodule

// File: rtl/dlw_mover.sv
module dlw_mover
  import dlw_pkg::*;
#(
  parameter int BAW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              pause,
  input  logic              start,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] lim,
  input  logic              eop_req,
  output logic              rd_en,
  output logic [BAW-1:0]    rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [BYTE_W-1:0] o_data,
  output logic              o_last,
  output logic              done
);
  typedef enum logic [1:0] {M_IDLE, M_RD, M_WAIT, M_HOLD} mst_t;

  mst_t              st;
  logic [WORD_W-1:0] cur, lim_q;
  logic              eop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= M_IDLE;
      cur     <= '0;
      lim_q   <= '0;
      eop_q   <= 1'b0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_last  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (flush) begin
        st      <= M_IDLE;
        o_valid <= 1'b0;
        o_last  <= 1'b0;
      end else begin
        case (st)
          M_IDLE: begin
            if (start) begin
              cur   <= src;
              lim_q <= lim;
              eop_q <= eop_req;
              if (src == lim) done <= 1'b1;
              else            st   <= M_RD;
            end
          end
          M_RD: if (!pause) st <= M_WAIT;
          M_WAIT: begin
            o_data  <= pick_byte(rd_data, cur[1:0]);
            o_valid <= 1'b1;
            o_last  <= eop_q && is_final_byte(cur, lim_q);
            st      <= M_HOLD;
          end
          default: begin
            if (o_ready) begin
              o_valid <= 1'b0;
              o_last  <= 1'b0;
              cur     <= cur + 32'd1;
              if (is_final_byte(cur, lim_q)) begin
                done <= 1'b1;
                st   <= M_IDLE;
              end else begin
                st <= M_RD;
              end
            end
          end
        endcase
      end
    end
  end

  assign rd_en   = (st == M_RD) && !pause && !flush;
  assign rd_addr = cur[BAW+1:2];

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n || flush)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_last));

  a_r3_single_beat: assert property (@(posedge clk) disable iff (!rst_n || flush)
    o_valid && o_ready |=> !o_valid);

  a_r5_eop_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    o_last |-> o_valid);

  a_r4_empty_done: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (st == M_IDLE) && start && (src == lim) |=> done && !o_valid);
endmodule

// File: rtl/dlist_stream_walker.sv
module dlist_stream_walker
  import dlw_pkg::*;
#(
  parameter int DESC_AW = 8,
  parameter int BUF_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_en,
  input  logic               ctl_stop,
  input  logic               cmd_cont,
  input  logic               irq_ack,
  input  logic [31:0]        first_desc_ptr,
  output logic               desc_rd_en,
  output logic [DESC_AW-1:0] desc_rd_addr,
  input  logic [31:0]        desc_rd_data,
  output logic               buf_rd_en,
  output logic [BUF_AW-1:0]  buf_rd_addr,
  input  logic [31:0]        buf_rd_data,
  output logic               st_valid,
  input  logic               st_ready,
  output logic [7:0]         st_data,
  output logic               st_eop,
  output logic               irq,
  output logic               at_end
);
  logic              mv_start, mv_eop, mv_done;
  logic [WORD_W-1:0] mv_src, mv_lim;
  logic              dsc_in_xfer, evt_desc_done;

  dlw_desc_seq #(.DAW(DESC_AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .pause(ctl_stop), .cont(cmd_cont),
    .irq_ack(irq_ack), .first_ptr(first_desc_ptr),
    .rd_en(desc_rd_en), .rd_addr(desc_rd_addr), .rd_data(desc_rd_data),
    .mv_start(mv_start), .mv_src(mv_src), .mv_lim(mv_lim), .mv_eop(mv_eop),
    .mv_done(mv_done), .in_xfer(dsc_in_xfer), .evt_desc_done(evt_desc_done),
    .irq(irq), .at_end(at_end)
  );

  dlw_mover #(.BAW(BUF_AW)) mover_i (
    .clk(clk), .rst_n(rst_n), .flush(!ctl_en), .pause(ctl_stop),
    .start(mv_start), .src(mv_src), .lim(mv_lim), .eop_req(mv_eop),
    .rd_en(buf_rd_en), .rd_addr(buf_rd_addr), .rd_data(buf_rd_data),
    .o_valid(st_valid), .o_ready(st_ready), .o_data(st_data), .o_last(st_eop),
    .done(mv_done)
  );

  a_r10_stop_blocks_reads: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stop |-> !buf_rd_en && !desc_rd_en);

  a_r11_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !st_valid && !buf_rd_en && !desc_rd_en);

  a_r7_done_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    mv_done |-> dsc_in_xfer);

  a_r6_done_after_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    evt_desc_done |-> !st_valid);
endmodule

// File: tb/dlist_stream_walker_tb_top.sv
`timescale 1ns/1ps
module dlist_stream_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0, ctl_stop = 1'b0, cmd_cont = 1'b0, irq_ack = 1'b0;
  logic [31:0] first_desc_ptr = '0;
  logic        desc_rd_en, buf_rd_en;
  logic [7:0]  desc_rd_addr, buf_rd_addr;
  logic [31:0] desc_rd_data = '0, buf_rd_data = '0;
  logic        st_valid, st_eop, irq, at_end;
  logic        st_ready = 1'b0;
  logic [7:0]  st_data;

  always #2 clk = ~clk;

  dlist_stream_walker dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_stop(ctl_stop), .cmd_cont(cmd_cont),
    .irq_ack(irq_ack), .first_desc_ptr(first_desc_ptr),
    .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_eop(st_eop),
    .irq(irq), .at_end(at_end)
  );

  logic [31:0] dmem [256];
  logic [31:0] bmem [256];
  always @(posedge clk) begin
    if (desc_rd_en) desc_rd_data <= dmem[desc_rd_addr];
    if (buf_rd_en)  buf_rd_data  <= bmem[buf_rd_addr];
  end

  int n_checks = 0, n_fail = 0;
  int beats = 0, eops = 0, stop_reads = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0]  exp_q [$];
  int unsigned dlog [$];
  int unsigned exp_rd [$];

  function automatic logic [7:0] byte_at(input int unsigned a);
    return 8'((a * 13 + 5) ^ (a >> 8));
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: update ready first, then sample the handshake that
  // the next rising edge will perform.
  always @(negedge clk) begin
    if (rdy_mode == 0) st_ready = 1'b1;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      st_ready = lfsr[0] | lfsr[3];
    end
    if (st_valid && st_ready) begin
      beats++;
      if (st_eop) eops++;
      if (exp_q.size() == 0) check(1'b0, "R3", "unexpected beat", st_data, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check(st_data == e[7:0], "R3", "beat byte", st_data, e[7:0]);
        check(st_eop == e[8], "R5", "beat eop", st_eop, e[8]);
      end
    end
    if (desc_rd_en) dlog.push_back(desc_rd_addr);
    if ((buf_rd_en || desc_rd_en) && ctl_stop) stop_reads++;
  end

  task automatic put_desc(input int unsigned at, input int unsigned nxt, input int unsigned s,
                          input int unsigned fl, input int unsigned e);
    dmem[at] = nxt; dmem[at+1] = s; dmem[at+2] = fl; dmem[at+3] = e;
  endtask

  task automatic push_bytes(input int unsigned s, input int unsigned e, input bit eop);
    for (int unsigned a = s; a != e; a++) exp_q.push_back({eop && (a + 1 == e), byte_at(a)});
  endtask

  task automatic expect_desc(input int unsigned at);
    for (int k = 0; k < 4; k++) exp_rd.push_back(at + k);
  endtask

  task automatic check_reads(input string tag);
    bit ok = (dlog.size() == exp_rd.size());
    check(ok, tag, "descriptor read count", dlog.size(), exp_rd.size());
    if (ok) for (int k = 0; k < dlog.size(); k++) if (dlog[k] != exp_rd[k]) ok = 1'b0;
    check(ok, tag, "descriptor read order", ok, 1);
    dlog.delete(); exp_rd.delete();
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!at_end && n < 2000) begin @(negedge clk); n++; end
    check(at_end, tag, "reached end of list", at_end, 1);
  endtask

  task automatic pulse_cont();
    cmd_cont = 1'b1; @(negedge clk); cmd_cont = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int b0, e0;
    for (int w = 0; w < 256; w++) begin
      bmem[w] = {byte_at(4*w+3), byte_at(4*w+2), byte_at(4*w+1), byte_at(4*w)};
      dmem[w] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!st_valid && !irq && !at_end && !desc_rd_en, "R11", "reset/idle state",
          {st_valid, irq, at_end, desc_rd_en}, 0);

    // Chain: A (7 bytes, packet end, inert bits), B (empty, irq), C (last, packet end)
    put_desc(32'h10, 32'h20, 32'h10, 32'hBEEF_0828, 32'h17);
    put_desc(32'h20, 32'h30, 32'h40, 32'h0000_0010, 32'h40);
    put_desc(32'h30, 32'h50, 32'h21, 32'h0000_0009, 32'h26);
    push_bytes(32'h10, 32'h17, 1'b1);
    push_bytes(32'h21, 32'h26, 1'b1);
    expect_desc(32'h10); expect_desc(32'h20); expect_desc(32'h30);
    rdy_mode = 1;
    first_desc_ptr = 32'h10;
    ctl_en = 1'b1;
    wait_end("R7");
    repeat (10) @(negedge clk);
    check(beats == 12 && exp_q.size() == 0, "R6", "all beats once under backpressure", beats, 12);
    check(eops == 2, "R5", "packet ends", eops, 2);
    check(irq, "R9", "irq after empty irq descriptor (R4)", irq, 1);
    check(at_end, "R7", "parked after last", at_end, 1);
    check_reads("R1");

    repeat (5) @(negedge clk);
    check(irq, "R9", "irq sticky", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check(!irq, "R9", "irq cleared by ack", irq, 0);

    // Reload with last bit still set
    pulse_cont();
    repeat (20) @(negedge clk);
    expect_desc(32'h30);
    check_reads("R8");
    check(at_end && beats == 12, "R8", "unchanged reload parks again", beats, 12);

    // Append D after C; D carries inert bits and no packet end
    put_desc(32'h60, 32'h70, 32'h83, 32'h1234_0821, 32'h89);
    dmem[32'h30] = 32'h60;
    dmem[32'h32] = 32'h0000_0008;
    push_bytes(32'h83, 32'h89, 1'b0);
    expect_desc(32'h30); expect_desc(32'h60);
    pulse_cont();
    @(negedge clk);
    wait_end("R8");
    repeat (4) @(negedge clk);
    check(beats == 18 && exp_q.size() == 0, "R8", "only appended buffer sent", beats, 18);
    check(eops == 2, "R2", "bits 5/11/meta give no packet end", eops, 2);
    check(!irq, "R9", "reload raises no irq", irq, 0);
    check_reads("R8");

    // Disable, then continue while idle is ignored
    ctl_en = 1'b0;
    @(negedge clk);
    check(!at_end && !st_valid, "R11", "idle after disable", at_end, 0);
    pulse_cont();
    repeat (5) @(negedge clk);
    check(dlog.size() == 0, "R12", "continue while idle ignored", dlog.size(), 0);

    // Pause mid-buffer with a stray continue
    put_desc(32'h90, 32'h00, 32'h101, 32'h0000_0019, 32'h11D);
    push_bytes(32'h101, 32'h11D, 1'b1);
    expect_desc(32'h90);
    rdy_mode = 0;
    first_desc_ptr = 32'h90;
    ctl_en = 1'b1;
    b0 = beats;
    while (beats < b0 + 5) @(negedge clk);
    ctl_stop = 1'b1;
    b0 = beats;
    @(negedge clk);
    pulse_cont();
    repeat (30) @(negedge clk);
    check(stop_reads == 0, "R10", "no reads while stopped", stop_reads, 0);
    check(beats - b0 <= 1, "R10", "at most the presented beat leaves", beats - b0, 1);
    check(!at_end, "R10", "still mid-buffer", at_end, 0);
    ctl_stop = 1'b0;
    wait_end("R10");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", "resume loses nothing", exp_q.size(), 0);
    check(irq, "R9", "irq from last descriptor", irq, 1);
    check_reads("R12");

    // Disable in the middle of a long buffer, then restart elsewhere
    ctl_en = 1'b0; @(negedge clk);
    put_desc(32'hA0, 32'h00, 32'h200, 32'h0000_0001, 32'h228);
    push_bytes(32'h200, 32'h228, 1'b0);
    first_desc_ptr = 32'hA0;
    rdy_mode = 1;
    ctl_en = 1'b1;
    b0 = beats;
    while (beats < b0 + 3) @(negedge clk);
    ctl_en = 1'b0;
    @(negedge clk);
    check(!st_valid && !buf_rd_en && !desc_rd_en, "R11", "quiet after mid-buffer disable",
          {st_valid, buf_rd_en, desc_rd_en}, 0);
    exp_q.delete(); dlog.delete();
    put_desc(32'hB0, 32'h00, 32'h301, 32'h0000_0009, 32'h304);
    push_bytes(32'h301, 32'h304, 1'b1);
    expect_desc(32'hB0);
    first_desc_ptr = 32'hB0;
    e0 = eops;
    ctl_en = 1'b1;
    wait_end("R11");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && eops == e0 + 1, "R11", "restart from new first pointer",
          exp_q.size(), 0);
    check_reads("R11");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule